// File: doc/BRIEF.md
# Resonant Half-Bridge Gate Sequencer

This block drives the two gates of a resonant half-bridge. A switching-phase input, produced elsewhere by the oscillator, selects which half of the bridge should conduct. The block turns that phase into two gate enables that never overlap and that are separated by a programmable dead time counted in system clocks. The high-side gate conducts in the high half of the phase and the low-side gate in the low half, so each gate gets the same on-time.

Protection sits on top of the pulse generation. A frequency-limit flag suppresses whole switching cycles. A fast overcurrent flag cuts both gates in the same cycle. A slow overcurrent flag trips only when it persists through eight consecutive switching cycles. After a trip the block waits out a fixed recovery interval and then asks for a new soft start.

Start-up is ordered. Nothing switches until the bulk supply reports ready. At that point a soft-start request goes up and switching begins at the next cycle boundary, always with the high side first.

Top module: `hb_gate_seq`

## Requirements
- R1: While reset is low, both gate outputs, the fault output and the soft-start request are 0, and the block afterwards waits for bulk-ready.
- R2: No gate turns on while `bulk_ok_i` is 0. The clock edge that samples it at 1 moves the block to run and raises `ss_req_o`. If `bulk_ok_i` drops during run, the block turns both gates off on the next clock and clears `ss_req_o`.
- R3: A change of `sw_phase_i` turns the conducting gate off on the edge that samples it. The other gate turns on D clocks later, where D = `dead_cfg_i`, and a value of 0 counts as 1. With a half-period of H clocks, each gate is therefore on for H-D clocks per cycle.
- R4: `gate_hi_o` and `gate_lo_o` are never 1 together.
- R5: After any enable, restart or unblanking, the first gate to turn on is the high side. A cycle starts on a rising edge of `sw_phase_i`, and phase value 1 selects the high side.
- R6: `flim_i` is sampled only at the rising edge of the phase. A cycle that starts with it at 1 is fully blanked, and a cycle that starts with it at 0 is fully driven, whatever `flim_i` does within that cycle.
- R7: While running, `ocp_fast_i` at 1 forces both gates to 0 combinationally in the same cycle, and `fault_o` is 1 after the next clock edge.
- R8: The block trips to fault at the rising phase edge that ends the eighth consecutive switching cycle in which `ocp_slow_i` was seen at 1. A cycle in which it was never seen clears the count.
- R9: `fault_o` stays 1 for exactly 1024 clocks, with both gates 0. The block then returns to waiting for bulk-ready and, if that is present, raises `ss_req_o` again.
- R10: `ss_req_o` falls on the clock edge after `ss_done_i` is sampled at 1 during run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_phase_i | input | 1 | Switching phase; 1 = high-side half, rising edge = cycle start |
| dead_cfg_i | input | 6 | Dead time in system clocks (0 acts as 1) |
| flim_i | input | 1 | Frequency-limit flag, blanks whole cycles |
| ocp_fast_i | input | 1 | Fast overcurrent comparator flag |
| ocp_slow_i | input | 1 | Slow overcurrent comparator flag |
| bulk_ok_i | input | 1 | Bulk voltage ready |
| ss_done_i | input | 1 | Soft start complete |
| gate_hi_o | output | 1 | High-side gate enable |
| gate_lo_o | output | 1 | Low-side gate enable |
| fault_o | output | 1 | Fault shutdown in progress |
| ss_req_o | output | 1 | Soft-start request |

## Verification
Several properties are checked on every clock: the gates never overlap, a phase change clears both gates, the cycle enable moves only at a cycle boundary, a fast trip raises the fault, the gates stay quiet during a fault, a fault cannot end while its timer still runs, and the slow count is cleared outside run. Other behaviour can only be shown by the bench's scenarios. These are the exact on-time for each dead-time setting, including 0, the high-side-first order, whole-cycle blanking when the limit flag toggles mid-cycle, a slow count that reaches seven and is then cleared by a clean cycle, the full 1024-clock recovery, and the return of the soft-start request.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;
   typedef enum logic [1:0] {
      ST_WAIT  = 2'd0,
      ST_RUN   = 2'd1,
      ST_FAULT = 2'd2
   } hb_state_t;
endpackage

// File: rtl/hb_nonoverlap.sv
module hb_nonoverlap #(
   parameter int DT_W        = 6,
   parameter int SYNC_STAGES = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sw_phase_i,
   input  logic [DT_W-1:0] dead_cfg_i,
   input  logic            run_ok_i,
   input  logic            flim_i,
   output logic            hi_o,
   output logic            lo_o,
   output logic            boundary_o
);
   localparam logic [DT_W-1:0] DT_ONE = DT_W'(1);

   logic            ph_in;
   logic            ph_q;
   logic            ph_edge;
   logic            ph_rise;
   logic [DT_W-1:0] dt_load;
   logic [DT_W-1:0] dt_cnt_q;
   logic            cyc_en_q;
   logic            hi_q;
   logic            lo_q;

   generate
      if (DT_W < 2) begin : g_bad_width
         $error("hb_nonoverlap: DT_W must be at least 2");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("hb_nonoverlap: SYNC_STAGES must not be negative");
      end
      if (SYNC_STAGES == 0) begin : g_direct
         assign ph_in = sw_phase_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], sw_phase_i};
         end
         assign ph_in = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   assign ph_edge    = ph_in ^ ph_q;
   assign ph_rise    = ph_in & ~ph_q;
   assign boundary_o = ph_rise;
   assign dt_load    = (dead_cfg_i == '0) ? DT_ONE : dead_cfg_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q     <= 1'b0;
         cyc_en_q <= 1'b0;
      end else begin
         ph_q <= ph_in;
         if (!run_ok_i)    cyc_en_q <= 1'b0;
         else if (ph_rise) cyc_en_q <= ~flim_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dt_cnt_q <= '0;
         hi_q     <= 1'b0;
         lo_q     <= 1'b0;
      end else if (ph_edge) begin
         dt_cnt_q <= dt_load - DT_ONE;
         hi_q     <= 1'b0;
         lo_q     <= 1'b0;
      end else if (dt_cnt_q != '0) begin
         dt_cnt_q <= dt_cnt_q - DT_ONE;
         hi_q     <= 1'b0;
         lo_q     <= 1'b0;
      end else begin
         hi_q <= ph_q & cyc_en_q & run_ok_i;
         lo_q <= ~ph_q & cyc_en_q & run_ok_i;
      end
   end

   assign hi_o = hi_q;
   assign lo_o = lo_q;

   assert_edge_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ph_edge |=> (!hi_q && !lo_q));

   assert_whole_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ph_rise && run_ok_i) |=> $stable(cyc_en_q));
endmodule

// File: rtl/hb_slow_ocp.sv
module hb_slow_ocp #(
   parameter int SLOW_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable_i,
   input  logic boundary_i,
   input  logic ocp_slow_i,
   output logic trip_o
);
   localparam int CW = (SLOW_CYCLES > 2) ? $clog2(SLOW_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(SLOW_CYCLES - 1);

   logic [CW-1:0] cnt_q;
   logic          seen_q;

   generate
      if (SLOW_CYCLES < 2) begin : g_bad_count
         $error("hb_slow_ocp: SLOW_CYCLES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         seen_q <= 1'b0;
      end else if (!enable_i) begin
         cnt_q  <= '0;
         seen_q <= 1'b0;
      end else if (boundary_i) begin
         seen_q <= ocp_slow_i;
         if (!seen_q)          cnt_q <= '0;
         else if (cnt_q != LAST) cnt_q <= cnt_q + CW'(1);
      end else begin
         seen_q <= seen_q | ocp_slow_i;
      end
   end

   assign trip_o = enable_i & boundary_i & seen_q & (cnt_q == LAST);

   assert_cnt_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !enable_i |=> (cnt_q == '0));
endmodule

// File: rtl/hb_seq_ctrl.sv
module hb_seq_ctrl
   import hb_gate_pkg::*;
#(
   parameter int RECOVER_CLKS = 1024
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      bulk_ok_i,
   input  logic      ocp_fast_i,
   input  logic      slow_trip_i,
   input  logic      ss_done_i,
   output hb_state_t state_o,
   output logic      ss_req_o
);
   localparam int TW = $clog2(RECOVER_CLKS);

   hb_state_t     state_q;
   logic [TW-1:0] timer_q;
   logic          ss_pend_q;

   generate
      if (RECOVER_CLKS < 2) begin : g_bad_recover
         $error("hb_seq_ctrl: RECOVER_CLKS must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_WAIT;
         timer_q   <= '0;
         ss_pend_q <= 1'b0;
      end else begin
         case (state_q)
            ST_WAIT: begin
               if (bulk_ok_i) begin
                  state_q   <= ST_RUN;
                  ss_pend_q <= 1'b1;
               end
            end
            ST_RUN: begin
               if (ss_done_i) ss_pend_q <= 1'b0;
               if (ocp_fast_i || slow_trip_i) begin
                  state_q   <= ST_FAULT;
                  timer_q   <= TW'(RECOVER_CLKS - 1);
                  ss_pend_q <= 1'b0;
               end else if (!bulk_ok_i) begin
                  state_q   <= ST_WAIT;
                  ss_pend_q <= 1'b0;
               end
            end
            ST_FAULT: begin
               if (timer_q == '0) state_q <= ST_WAIT;
               else               timer_q <= timer_q - TW'(1);
            end
            default: state_q <= ST_WAIT;
         endcase
      end
   end

   assign state_o  = state_q;
   assign ss_req_o = (state_q == ST_RUN) & ss_pend_q;

   assert_fault_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FAULT && timer_q != '0) |=> (state_q == ST_FAULT));

   assert_bulk_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT && bulk_ok_i) |=> ss_req_o);
endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq
   import hb_gate_pkg::*;
#(
   parameter int DT_W         = 6,
   parameter int SLOW_CYCLES  = 8,
   parameter int RECOVER_CLKS = 1024,
   parameter int SYNC_STAGES  = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sw_phase_i,
   input  logic [DT_W-1:0] dead_cfg_i,
   input  logic            flim_i,
   input  logic            ocp_fast_i,
   input  logic            ocp_slow_i,
   input  logic            bulk_ok_i,
   input  logic            ss_done_i,
   output logic            gate_hi_o,
   output logic            gate_lo_o,
   output logic            fault_o,
   output logic            ss_req_o
);
   hb_state_t state;
   logic      in_run;
   logic      hi_raw;
   logic      lo_raw;
   logic      boundary;
   logic      slow_trip;

   assign in_run = (state == ST_RUN);

   hb_nonoverlap #(
      .DT_W        (DT_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) i_nonoverlap (
      .clk        (clk),
      .rst_n      (rst_n),
      .sw_phase_i (sw_phase_i),
      .dead_cfg_i (dead_cfg_i),
      .run_ok_i   (in_run),
      .flim_i     (flim_i),
      .hi_o       (hi_raw),
      .lo_o       (lo_raw),
      .boundary_o (boundary)
   );

   hb_slow_ocp #(
      .SLOW_CYCLES (SLOW_CYCLES)
   ) i_slow_ocp (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable_i   (in_run),
      .boundary_i (boundary),
      .ocp_slow_i (ocp_slow_i),
      .trip_o     (slow_trip)
   );

   hb_seq_ctrl #(
      .RECOVER_CLKS (RECOVER_CLKS)
   ) i_seq_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .bulk_ok_i   (bulk_ok_i),
      .ocp_fast_i  (ocp_fast_i),
      .slow_trip_i (slow_trip),
      .ss_done_i   (ss_done_i),
      .state_o     (state),
      .ss_req_o    (ss_req_o)
   );

   assign gate_hi_o = hi_raw & in_run & ~ocp_fast_i;
   assign gate_lo_o = lo_raw & in_run & ~ocp_fast_i;
   assign fault_o   = (state == ST_FAULT);

   assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi_o && gate_lo_o));

   assert_fault_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> (!gate_hi_o && !gate_lo_o));

   assert_fast_trip_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_run && ocp_fast_i) |=> fault_o);
endmodule

// File: tb/test_hb_gate_seq.sv
module test_hb_gate_seq;
   localparam int H  = 40;
   localparam int NV = 7;
   localparam int VCFG [NV] = '{0, 1, 2, 7, 20, 39, 3};
   localparam int VFL  [NV] = '{0, 0, 0, 0, 0, 0, 1};
   localparam int VEXP [NV] = '{39, 39, 38, 33, 20, 1, 0};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sw_phase = 1'b0;
   logic [5:0] dead_cfg = 6'd5;
   logic       flim = 1'b0;
   logic       ocp_fast = 1'b0;
   logic       ocp_slow = 1'b0;
   logic       bulk_ok = 1'b0;
   logic       ss_done = 1'b0;
   logic       gate_hi, gate_lo, fault, ss_req;

   int tests = 0;
   int fails = 0;
   int hic, loc, ovl, fcnt, first;
   bit done = 1'b0;

   always #2 clk = ~clk;

   hb_gate_seq i_hb_gate_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .sw_phase_i (sw_phase),
      .dead_cfg_i (dead_cfg),
      .flim_i     (flim),
      .ocp_fast_i (ocp_fast),
      .ocp_slow_i (ocp_slow),
      .bulk_ok_i  (bulk_ok),
      .ss_done_i  (ss_done),
      .gate_hi_o  (gate_hi),
      .gate_lo_o  (gate_lo),
      .fault_o    (fault),
      .ss_req_o   (ss_req)
   );

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic run_cycle(input logic slow_v, input int chg_idx, input logic flim_new);
      hic = 0; loc = 0; ovl = 0; fcnt = 0; first = 0;
      for (int i = 0; i < 2 * H; i++) begin
         sw_phase = (i < H);
         if (i == 0) ocp_slow = slow_v;
         if (i == chg_idx) flim = flim_new;
         @(negedge clk);
         if (gate_hi) hic++;
         if (gate_lo) loc++;
         if (gate_hi && gate_lo) ovl++;
         if (fault) fcnt++;
         if (first == 0 && gate_hi) first = 1;
         else if (first == 0 && gate_lo) first = 2;
      end
   endtask

   task automatic wait_recovery(input string req, input int already);
      int n;
      n = already;
      forever begin
         @(negedge clk);
         if (!fault) break;
         n++;
         if (gate_hi || gate_lo) chk({req, " gates off in fault"}, 1, 0);
      end
      chk({req, " fault length"}, n, 1024);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 hi in reset", gate_hi, 0);
      chk("R1 lo in reset", gate_lo, 0);
      chk("R1 fault in reset", fault, 0);
      chk("R1 ss_req in reset", ss_req, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: no switching before bulk ready
      run_cycle(1'b0, -1, 1'b0);
      chk("R2 no hi before bulk", hic, 0);
      chk("R2 no lo before bulk", loc, 0);
      chk("R2 no ss_req before bulk", ss_req, 0);
      sw_phase = 1'b0;
      bulk_ok = 1'b1;
      @(negedge clk);
      chk("R2 ss_req on bulk", ss_req, 1);

      // R3/R4/R5/R6: vector table
      for (int v = 0; v < NV; v++) begin
         dead_cfg = 6'(VCFG[v]);
         flim = VFL[v][0];
         run_cycle(1'b0, -1, 1'b0);
         chk($sformatf("R3 hi on-time vec%0d", v), hic, VEXP[v]);
         chk($sformatf("R3 lo on-time vec%0d", v), loc, VEXP[v]);
         chk($sformatf("R4 overlap vec%0d", v), ovl, 0);
         if (VEXP[v] > 0) chk($sformatf("R5 hi first vec%0d", v), first, 1);
      end

      // R6: limit flag changing within a cycle
      flim = 1'b0;
      dead_cfg = 6'd5;
      run_cycle(1'b0, 5, 1'b1);
      chk("R6 set mid-cycle keeps hi", hic, 35);
      chk("R6 set mid-cycle keeps lo", loc, 35);
      run_cycle(1'b0, -1, 1'b1);
      chk("R6 blanked cycle", hic + loc, 0);
      run_cycle(1'b0, 5, 1'b0);
      chk("R6 clear mid-cycle stays blank", hic + loc, 0);
      run_cycle(1'b0, -1, 1'b0);
      chk("R6 unblanked hi", hic, 35);
      chk("R5 hi first after unblank", first, 1);

      // R10: soft-start done
      chk("R10 ss_req before done", ss_req, 1);
      ss_done = 1'b1;
      @(negedge clk);
      chk("R10 ss_req after done", ss_req, 0);
      ss_done = 1'b0;

      // R8: seven slow cycles, a clean one, then eight slow cycles
      for (int c = 0; c < 7; c++) run_cycle(1'b1, -1, 1'b0);
      run_cycle(1'b0, -1, 1'b0);
      for (int c = 0; c < 8; c++) run_cycle(1'b1, -1, 1'b0);
      chk("R8 no trip after count reset", fault, 0);
      chk("R8 still driving", hic, 35);
      run_cycle(1'b1, -1, 1'b0);
      chk("R8 trip on eighth cycle", fault, 1);
      chk("R8 gates off after trip", hic + loc, 0);
      ocp_slow = 1'b0;
      sw_phase = 1'b0;
      wait_recovery("R9 slow", fcnt);
      @(negedge clk);
      chk("R9 ss_req after recovery", ss_req, 1);
      run_cycle(1'b0, -1, 1'b0);
      chk("R5 hi first after restart", first, 1);
      chk("R9 hi after restart", hic, 35);

      // R7: fast overcurrent mid pulse
      sw_phase = 1'b1;
      repeat (10) @(negedge clk);
      chk("R7 hi on before trip", gate_hi, 1);
      ocp_fast = 1'b1;
      #1;
      chk("R7 hi off at once", gate_hi, 0);
      chk("R7 lo off at once", gate_lo, 0);
      @(negedge clk);
      chk("R7 fault after clock", fault, 1);
      ocp_fast = 1'b0;
      wait_recovery("R9 fast", 1);
      @(negedge clk);
      chk("R9 ss_req after fast recovery", ss_req, 1);
      sw_phase = 1'b0;
      @(negedge clk);
      run_cycle(1'b0, -1, 1'b0);
      chk("R5 hi first after fast restart", first, 1);

      // R2: bulk loss
      sw_phase = 1'b1;
      repeat (10) @(negedge clk);
      bulk_ok = 1'b0;
      @(negedge clk);
      chk("R2 hi off on bulk loss", gate_hi, 0);
      chk("R2 ss_req off on bulk loss", ss_req, 0);
      sw_phase = 1'b0;
      @(negedge clk);
      run_cycle(1'b0, -1, 1'b0);
      chk("R2 no switching after bulk loss", hic + loc, 0);

      // R1: asynchronous reset mid pulse
      bulk_ok = 1'b1;
      @(negedge clk);
      run_cycle(1'b0, -1, 1'b0);
      sw_phase = 1'b1;
      repeat (10) @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1 hi low in async reset", gate_hi, 0);
      chk("R1 ss_req low in async reset", ss_req, 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule